// File: doc/BRIEF.md
# SPI Flash User-Mode Host Controller

This block is a host-side SPI controller that serves two flash chip selects under direct software control. A small register bus carries four registers and two byte-wide data windows. Software sets up a chip select's clock mode, divider and operating mode, then asserts the select by clearing its stop bit. Each single-byte access to that select's data window then moves exactly one byte on the SPI wires. A write shifts the byte out MSB-first. A read shifts a byte in while MOSI is held low. The select stays asserted across any number of bytes until software sets the stop bit again.

Register map (byte offsets on `bus_addr[7:0]` when `bus_addr[9:8]` is 0):
- 0x00: write-enable flags.
- 0x04: polarity register.
- 0x10: control word for select 0.
- 0x14: control word for select 1.

The data window for select 0 spans 0x100 to 0x1FF, and the one for select 1 spans 0x200 to 0x3FF. A data-window access holds `bus_ready` low until the byte has finished, so the bus master stalls for the whole transfer. A register access completes in the cycle it is presented.

Top module: `spi_user_ctrl`

## Requirements
- R1: After reset both control words read 0x00000007 (user mode 3, stop bit set, divider code 0, clock mode 0). Offsets 0x00 and 0x04 read 0. `spi_cs` is 2'b11 and `spi_sck` is low.
- R2: The fields of each control word read back as written: mode at bits 1:0, stop at bit 2, clock mode at bit 4, divider code at bits 11:8, divide-by-4 at bit 13, extended nibble at bits 27:24. All other bits read 0.
- R3: Clearing the stop bit (bit 2) of select 0 drives `spi_cs[0]` low. The pin stays low across successive byte transfers and returns high once bit 2 is set again.
- R4: Select 1 follows bit 1 of offset 0x04. When that bit is 1, `spi_cs[1]` is high while select 1 is asserted and low while it is stopped. Select 0 is always active-low.
- R5: A write to a data window puts the byte on `spi_mosi` MSB-first, with each bit stable around a rising SCK edge. Exactly eight rising edges occur per byte.
- R6: A read from a data window samples `spi_miso` on the eight rising SCK edges, MSB first. The byte is returned on `bus_rdata[7:0]` in the ready cycle, and `spi_mosi` stays low during the read.
- R7: Each SCK half-period lasts N clock cycles. N is 16 times the extended nibble plus the mapped code value, and is multiplied by 4 when bit 13 is set. The code map is 15→1, 7→2, 14→3, 6→4, 13→5, 5→6, 12→7, 4→8, 11→9, 3→10, 10→11, 2→12, 9→13, 1→14, 8→15, 0→16.
- R8: Bit 4 of a control word selects clock mode 3. In that mode SCK idles high; otherwise it idles low. Data is sampled on the rising edge in both modes.
- R9: A write to a select's data window is dropped unless its enable flag is set (offset 0x00, bit 16 for select 0, bit 17 for select 1). The access still completes, with no SCK edge.
- R10: A data-window access to a select whose mode bits are not 3 moves no data, completes with no SCK edge, and reads 0.
- R11: A data-window access raises `bus_ready` for one cycle, exactly 16·N+1 cycles after it is presented. `bus_ready` is never high without `bus_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request, held until `bus_ready` |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Access complete |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 2 | Chip select pins, select 0 in bit 0 |

## Verification
The bench sweeps the scrambled divider code through both halves of its map, and also through the extended nibble and the divide-by-4 bit. It measures the time between SCK rising edges. A decoder that read the code as a plain binary count would show up as a wrong edge spacing. It also runs byte patterns with a lone MSB or a lone LSB set, in both clock modes. This catches bit-order reversal, an off-by-one in the shift count, and sampling on the wrong edge. Write-enable gating, non-user-mode accesses and select 1's polarity are each probed at the pins. A design that leaked an ignored write would produce SCK edges. A design with the polarity inverted would show the wrong level on `spi_cs[1]` while the select is held.

// File: rtl/spi_user_ctrl.sv
module spi_user_ctrl #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        spi_cs
);
  localparam int WIN_HI = ADDR_W - 1;
  localparam int WIN_LO = ADDR_W - 2;
  localparam int LAST_HALF = 15;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DONE} state_t;

  logic [1:0] wr_en;
  logic       cs1_high;
  logic [1:0] mode [2];
  logic       stop [2];
  logic       cpol [2];
  logic [3:0] code [2];
  logic [3:0] ext  [2];
  logic       div4 [2];

  state_t     state;
  logic       cur;
  logic       is_wr;
  logic [7:0] tx, rx;
  logic [3:0] half;
  logic [CNT_W-1:0] cnt;

  logic is_win, win_cs, reg_wr, idx;
  assign is_win = |bus_addr[WIN_HI:WIN_LO];
  assign win_cs = bus_addr[WIN_HI];
  assign idx    = bus_addr[2];
  assign reg_wr = bus_sel && bus_we && !is_win;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:28], bus_wdata[23:18], bus_wdata[15:14], bus_wdata[12]};

  function automatic logic [CNT_W-1:0] half_len(input logic [3:0] c, input logic [3:0] e, input logic q);
    logic [CNT_W-1:0] b;
    b = CNT_W'(e) * CNT_W'(16) + CNT_W'(16) - CNT_W'({c[2:0], 1'b0}) - CNT_W'(c[3]);
    return q ? (b << 2) : b;
  endfunction

  function automatic logic [31:0] ctrl_word(input int i);
    return {4'b0, ext[i], 10'b0, div4[i], 1'b0, code[i], 3'b0, cpol[i], 1'b0, stop[i], mode[i]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= '0;
      cs1_high <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        mode[i] <= 2'd3;
        stop[i] <= 1'b1;
        cpol[i] <= 1'b0;
        code[i] <= '0;
        ext[i]  <= '0;
        div4[i] <= 1'b0;
      end
    end else if (reg_wr) begin
      case (bus_addr[7:0])
        8'h00: wr_en <= bus_wdata[17:16];
        8'h04: cs1_high <= bus_wdata[1];
        8'h10, 8'h14: begin
          mode[idx] <= bus_wdata[1:0];
          stop[idx] <= bus_wdata[2];
          cpol[idx] <= bus_wdata[4];
          code[idx] <= bus_wdata[11:8];
          div4[idx] <= bus_wdata[13];
          ext[idx]  <= bus_wdata[27:24];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur   <= 1'b0;
      is_wr <= 1'b0;
      tx    <= '0;
      rx    <= '0;
      half  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (bus_sel && is_win) begin
          cur <= win_cs;
          rx  <= '0;
          if (mode[win_cs] == 2'd3 && (!bus_we || wr_en[win_cs])) begin
            state <= S_SHIFT;
            is_wr <= bus_we;
            tx    <= bus_wdata[7:0];
            half  <= '0;
            cnt   <= half_len(code[win_cs], ext[win_cs], div4[win_cs]) - CNT_W'(1);
          end else begin
            state <= S_DONE;
          end
        end
        S_SHIFT: begin
          if (cnt == '0) begin
            if (!half[0]) rx <= {rx[6:0], spi_miso};
            if (half == 4'(LAST_HALF)) begin
              state <= S_DONE;
            end else begin
              half <= half + 4'd1;
              cnt  <= half_len(code[cur], ext[cur], div4[cur]) - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign spi_sck  = (state == S_SHIFT) ? half[0] : cpol[cur];
  assign spi_mosi = (state == S_SHIFT && is_wr) ? tx[3'd7 - half[3:1]] : 1'b0;
  assign spi_cs   = {cs1_high ? ~stop[1] : stop[1], stop[0]};

  assign bus_ready = bus_sel && (is_win ? (state == S_DONE) : 1'b1);

  always_comb begin
    bus_rdata = '0;
    if (is_win) begin
      if (state == S_DONE) bus_rdata = {24'b0, rx};
    end else begin
      case (bus_addr[7:0])
        8'h00: bus_rdata = {14'b0, wr_en, 16'b0};
        8'h04: bus_rdata = {30'b0, cs1_high, 1'b0};
        8'h10: bus_rdata = ctrl_word(0);
        8'h14: bus_rdata = ctrl_word(1);
        default: ;
      endcase
    end
  end

  p_ready_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> bus_sel);

  p_cs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && $past(state) == S_SHIFT) |-> $stable(spi_cs));

  p_mosi_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && $past(state) == S_SHIFT && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  p_blocked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && bus_sel && bus_we && is_win && !wr_en[win_cs]) |=> (state == S_DONE));
endmodule

// File: tb/sim_spi_user_ctrl.sv
module sim_spi_user_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, spi_sck, spi_mosi, spi_miso;
  logic [1:0] spi_cs;

  always #5 clk = ~clk;

  spi_user_ctrl u0 (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                    .bus_ready, .spi_sck, .spi_mosi, .spi_miso, .spi_cs);

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] slv_byte = '0, cap = '0;
  int rises = 0;
  time t0 = 0, t1 = 0;
  bit rd_watch = 0, mosi_bad = 0;

  assign spi_miso = slv_byte[3'd7 - 3'(rises)];

  always @(posedge spi_sck) begin
    cap = {cap[6:0], spi_mosi};
    if (rises == 0) t0 = $time;
    if (rises == 1) t1 = $time;
    rises = rises + 1;
  end

  always @(posedge clk) if (rd_watch && spi_mosi) mosi_bad = 1;

  localparam logic [25:0] VEC [6] = '{
    {4'hF, 4'h0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {4'h0, 4'h0, 1'b0, 1'b0, 8'h01, 8'h80},
    {4'h7, 4'h0, 1'b1, 1'b1, 8'hC3, 8'h5A},
    {4'hE, 4'h1, 1'b0, 1'b0, 8'h7E, 8'hE7},
    {4'h9, 4'h0, 1'b1, 1'b0, 8'h80, 8'h01},
    {4'h8, 4'h2, 1'b0, 1'b1, 8'hFF, 8'h00}
  };

  function automatic int code_map(input logic [3:0] c);
    case (c)
      4'd15: return 1;  4'd7: return 2;  4'd14: return 3;  4'd6: return 4;
      4'd13: return 5;  4'd5: return 6;  4'd12: return 7;  4'd4: return 8;
      4'd11: return 9;  4'd3: return 10; 4'd10: return 11; 4'd2: return 12;
      4'd9:  return 13; 4'd1: return 14; 4'd8:  return 15; default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [9:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int n);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    n = 0;
    #1;
    while (!bus_ready) begin
      @(negedge clk);
      n++;
      #1;
    end
    rd = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  function automatic logic [31:0] cword(input logic [3:0] c, input logic [3:0] e, input logic q,
                                        input logic p, input logic s, input logic [1:0] m);
    return {4'b0, e, 10'b0, q, 1'b0, c, 3'b0, p, 1'b0, s, m};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bus(0, 10'h010, 0, rd, n); check(rd == 32'h7, "R1 ctrl0", rd, 7);
    bus(0, 10'h014, 0, rd, n); check(rd == 32'h7, "R1 ctrl1", rd, 7);
    bus(0, 10'h000, 0, rd, n); check(rd == 0, "R1 cfg", rd, 0);
    bus(0, 10'h004, 0, rd, n); check(rd == 0, "R1 pol", rd, 0);
    check(spi_cs == 2'b11, "R1 cs", spi_cs, 3);
    check(spi_sck == 0, "R1 sck", spi_sck, 0);

    // R9 write blocked without enable
    rises = 0;
    bus(1, 10'h100, 32'h55, rd, n);
    check(rises == 0, "R9 no sck edge", rises, 0);
    check(n == 1, "R9 quick complete", n, 1);

    bus(1, 10'h000, 32'h0003_0000, rd, n);
    check(rd == 0 || 1, "R9 cfg write", 0, 0);
    bus(0, 10'h000, 0, rd, n); check(rd == 32'h0003_0000, "R2 cfg readback", rd, 32'h30000);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [3:0] c, e; logic q, p; logic [7:0] txb, sb; int len; logic [31:0] w;
      {c, e, q, p, txb, sb} = VEC[v];
      len = (16 * e + code_map(c)) * (q ? 4 : 1);
      w = cword(c, e, q, p, 1'b0, 2'd3);
      bus(1, 10'h010, w | 32'hF0FC_C0E8, rd, n);
      bus(0, 10'h010, 0, rd, n); check(rd == w, "R2 ctrl readback", rd, w);
      check(spi_cs[0] == 0, "R3 cs asserted", spi_cs, 0);
      check(spi_sck == p, "R8 idle level", spi_sck, p);
      rises = 0; cap = 0;
      bus(1, 10'h100, {24'hFFFFFF, txb}, rd, n);
      check(cap == txb, "R5 mosi byte", cap, txb);
      check(rises == 8, "R5 edge count", rises, 8);
      check((t1 - t0) == longint'(2 * len * 10), "R7 sck period", t1 - t0, 2 * len * 10);
      check(n == 16 * len + 1, "R11 stall cycles", n, 16 * len + 1);
      check(spi_cs[0] == 0, "R3 cs held between bytes", spi_cs, 0);
      rises = 0; slv_byte = sb; mosi_bad = 0; rd_watch = 1;
      bus(0, 10'h100, 0, rd, n);
      rd_watch = 0;
      check(rd == {24'b0, sb}, "R6 read byte", rd, sb);
      check(!mosi_bad, "R6 mosi low", mosi_bad, 0);
      check(spi_sck == p, "R8 idle after transfer", spi_sck, p);
    end

    // R3 stop deasserts
    bus(1, 10'h010, cword(4'hF, 0, 0, 0, 1'b1, 2'd3), rd, n);
    check(spi_cs[0] == 1, "R3 cs released", spi_cs, 1);

    // R10 non-user mode
    bus(1, 10'h010, cword(4'hF, 0, 0, 0, 1'b0, 2'd1), rd, n);
    rises = 0; slv_byte = 8'hFF;
    bus(0, 10'h100, 0, rd, n);
    check(rd == 0, "R10 read zero", rd, 0);
    check(rises == 0, "R10 no sck edge", rises, 0);

    // R4 select 1 active-high
    bus(1, 10'h004, 32'h2, rd, n);
    check(spi_cs[1] == 0, "R4 cs1 stopped low", spi_cs, 0);
    bus(1, 10'h014, cword(4'hF, 0, 0, 0, 1'b0, 2'd3), rd, n);
    check(spi_cs[1] == 1, "R4 cs1 asserted high", spi_cs, 2);
    rises = 0; cap = 0;
    bus(1, 10'h200, 32'h96, rd, n);
    check(cap == 8'h96, "R5 cs1 write", cap, 8'h96);
    check(spi_cs[1] == 1, "R4 cs1 held", spi_cs, 2);
    bus(1, 10'h014, cword(4'hF, 0, 0, 0, 1'b1, 2'd3), rd, n);
    check(spi_cs[1] == 0, "R4 cs1 released", spi_cs, 0);

    // R9 select 1 enable cleared
    bus(1, 10'h000, 32'h0001_0000, rd, n);
    bus(1, 10'h014, cword(4'hF, 0, 0, 0, 1'b0, 2'd3), rd, n);
    rises = 0;
    bus(1, 10'h200, 32'h33, rd, n);
    check(rises == 0, "R9 cs1 write blocked", rises, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule